// File: doc/BRIEF.md
# VGA Planar Memory Read Path

This block answers byte-granular reads aimed at the 64 KiB graphics window of a four-plane display memory. A read request carries a window address and a byte count. The block turns each byte of the request into at most one access on a 32-bit plane memory port, where one word holds one byte from each of the four planes. It collects the bytes into a little-endian response word and hands that word back over a valid/ready handshake.

Three addressing schemes are chosen by configuration inputs: chain-4 linear addressing, odd/even text mapping, and planar access. A planar access loads a 32-bit latch. From that latch the block returns either a single plane byte or a colour-compare match byte. The latch is an output, so the write path can use it. Only planar reads change it.

Top module: `vga_rd_path`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1 and latch_q is 0.
- R2: The request address is a 17-bit window offset. Byte addresses advance modulo 2^17. A byte whose address is 0x10000 or above reads as 0xFF and causes no memory access.
- R3: With cfg_chain4 set, byte address b is read from word b>>2 of the plane memory, byte lane b[1:0], where lane n is bits [8n+7:8n].
- R4: With cfg_chain4 clear and cfg_odd_even set, the plane is {cfg_plane_sel[1], b[0]}. The byte is taken from memory byte address ((b with bit 0 cleared)<<1) | plane, which is mapped to a word and lane as in R3.
- R5: With both cfg_chain4 and cfg_odd_even clear, word b of the plane memory is loaded into latch_q, with plane n in bits [8n+7:8n].
- R6: In planar mode with cfg_cmp_mode clear, the returned byte is latch plane cfg_plane_sel.
- R7: In planar mode with cfg_cmp_mode set, each 4-bit value is expanded so that set bit n gives 0xFF in lane n. The returned byte is the inverse of the OR of the four lanes of ((latch XOR expanded cfg_cmp_color) AND expanded cfg_cmp_care).
- R8: Sizes 2 and 4 read bytes b, b+1, and so on, and pack byte i into rsp_data[8i+7:8i]. Unused upper bytes are 0. Any size other than 1, 2 or 4 returns 0 with no memory access.
- R9: latch_q changes only on a planar-mode in-window byte read.
- R10: req_ready is 1 only while no request is in flight. rsp_valid and rsp_data hold steady until rsp_ready is seen.
- R11: Each in-window byte issues exactly one mem_rd_en pulse, and mem_rdata is used on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | 17 | Window byte address |
| req_size | input | 3 | Byte count (1, 2 or 4) |
| rsp_valid | output | 1 | Response data present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Packed read data |
| mem_rd_en | output | 1 | Plane memory read strobe |
| mem_word_addr | output | 16 | Plane memory word address |
| mem_rdata | input | 32 | Plane memory word, valid the cycle after mem_rd_en |
| cfg_chain4 | input | 1 | Chain-4 addressing select |
| cfg_odd_even | input | 1 | Odd/even addressing select |
| cfg_cmp_mode | input | 1 | Planar read returns the colour-compare result |
| cfg_plane_sel | input | 2 | Plane for planar reads; bit 1 is the odd/even plane high bit |
| cfg_cmp_color | input | 4 | Colour-compare value |
| cfg_cmp_care | input | 4 | Colour don't-care mask |
| latch_q | output | 32 | Plane latch |

## Verification
Take the accepting clock edge as edge 0. From there the response becomes valid after a count of edges that depends only on the request. Each in-window byte adds two edges, one to issue and one to capture. Each out-of-window byte adds one edge. An unsupported size adds none.

The bench works this count out from its own model before it drives the request. It then counts edges until rsp_valid rises and compares that count, the data and the number of memory strobes. Every sample is taken on the falling edge. The latch is compared after each response. The response is then held back for a few cycles to confirm that it stays stable.

// File: rtl/vgard_pkg.sv
package vgard_pkg;

  typedef enum logic [1:0] {
    MAP_CHAIN4  = 2'd0,
    MAP_ODDEVEN = 2'd1,
    MAP_PLANAR  = 2'd2
  } map_kind_e;

  // Each set bit n of a nibble becomes an all-ones byte in lane n.
  function automatic logic [31:0] spread_nibble(input logic [3:0] nib);
    logic [31:0] r;
    for (int n = 0; n < 4; n++) r[8*n +: 8] = {8{nib[n]}};
    return r;
  endfunction

  function automatic logic [7:0] lane_pick(input logic [31:0] w, input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction

  // Colour compare: a lane bit is 1 when every cared plane matches.
  function automatic logic [7:0] compare_fold(input logic [31:0] w,
                                              input logic [3:0]  color,
                                              input logic [3:0]  care);
    logic [31:0] diff;
    logic [7:0]  acc;
    diff = (w ^ spread_nibble(color)) & spread_nibble(care);
    acc  = '0;
    for (int n = 0; n < 4; n++) acc = acc | diff[8*n +: 8];
    return ~acc;
  endfunction

endpackage

// File: rtl/vgard_addr_map.sv
module vgard_addr_map
  import vgard_pkg::*;
#(
  parameter int WIN_AW = 17,
  parameter int MEM_AW = 16
) (
  input  logic [WIN_AW-1:0] byte_addr,
  input  logic              chain4,
  input  logic              odd_even,
  input  logic              plane_hi,
  output logic              out_of_window,
  output map_kind_e         kind,
  output logic [MEM_AW-1:0] word_addr,
  output logic [1:0]        lane
);
  localparam int OFF_W = WIN_AW - 1;
  localparam int VB_W  = MEM_AW + 2;

  logic [OFF_W-1:0] off;
  logic [1:0]       oe_plane;
  logic [VB_W-1:0]  vbyte;

  always_comb begin
    off           = byte_addr[OFF_W-1:0];
    out_of_window = byte_addr[WIN_AW-1];
    oe_plane      = {plane_hi, off[0]};
    if (chain4) begin
      kind  = MAP_CHAIN4;
      vbyte = VB_W'(off);
    end else if (odd_even) begin
      kind  = MAP_ODDEVEN;
      vbyte = VB_W'({off[OFF_W-1:1], oe_plane});
    end else begin
      kind  = MAP_PLANAR;
      vbyte = {MEM_AW'(off), 2'b00};
    end
    word_addr = vbyte[VB_W-1:2];
    lane      = vbyte[1:0];
  end

endmodule

// File: rtl/vgard_data_sel.sv
module vgard_data_sel
  import vgard_pkg::*;
(
  input  map_kind_e   kind,
  input  logic [1:0]  lane,
  input  logic [31:0] mem_rdata,
  input  logic        capture,
  input  logic        cmp_mode,
  input  logic [1:0]  plane_sel,
  input  logic [3:0]  cmp_color,
  input  logic [3:0]  cmp_care,
  output logic [7:0]  byte_val,
  output logic        latch_load,
  output logic [31:0] latch_next
);
  always_comb begin
    latch_next = mem_rdata;
    latch_load = capture && (kind == MAP_PLANAR);
    if (kind == MAP_PLANAR) begin
      byte_val = cmp_mode ? compare_fold(mem_rdata, cmp_color, cmp_care)
                          : lane_pick(mem_rdata, plane_sel);
    end else begin
      byte_val = lane_pick(mem_rdata, lane);
    end
  end

endmodule

// File: rtl/vga_rd_path.sv
module vga_rd_path
  import vgard_pkg::*;
#(
  parameter int WIN_AW    = 17,
  parameter int MEM_AW    = 16,
  parameter int RSP_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [WIN_AW-1:0]    req_addr,
  input  logic [$clog2(RSP_BYTES):0] req_size,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [8*RSP_BYTES-1:0] rsp_data,
  output logic                 mem_rd_en,
  output logic [MEM_AW-1:0]    mem_word_addr,
  input  logic [31:0]          mem_rdata,
  input  logic                 cfg_chain4,
  input  logic                 cfg_odd_even,
  input  logic                 cfg_cmp_mode,
  input  logic [1:0]           cfg_plane_sel,
  input  logic [3:0]           cfg_cmp_color,
  input  logic [3:0]           cfg_cmp_care,
  output logic [31:0]          latch_q
);
  localparam int IDX_W  = $clog2(RSP_BYTES);
  localparam int CNT_W  = IDX_W + 1;
  localparam int DATA_W = 8 * RSP_BYTES;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} rd_state_e;

  rd_state_e         state_q;
  logic [WIN_AW-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;

  // Named internal events used by the checker.
  logic              oob_w;
  logic              byte_capture_w;
  logic              latch_load_w;
  logic              last_byte_w;
  logic              size_ok_w;
  logic [WIN_AW-1:0] cur_addr_w;
  map_kind_e         kind_w;
  logic [1:0]        lane_w;
  logic [7:0]        byte_w;
  logic [31:0]       latch_next_w;

  assign cur_addr_w     = base_q + WIN_AW'(idx_q);
  assign last_byte_w    = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;
  assign byte_capture_w = (state_q == ST_WAIT);
  assign size_ok_w      = (req_size != '0) && ((req_size & (req_size - CNT_W'(1))) == '0)
                          && (req_size <= CNT_W'(RSP_BYTES));

  vgard_addr_map #(.WIN_AW(WIN_AW), .MEM_AW(MEM_AW)) addr_map_i (
    .byte_addr    (cur_addr_w),
    .chain4       (cfg_chain4),
    .odd_even     (cfg_odd_even),
    .plane_hi     (cfg_plane_sel[1]),
    .out_of_window(oob_w),
    .kind         (kind_w),
    .word_addr    (mem_word_addr),
    .lane         (lane_w)
  );

  vgard_data_sel data_sel_i (
    .kind      (kind_w),
    .lane      (lane_w),
    .mem_rdata (mem_rdata),
    .capture   (byte_capture_w),
    .cmp_mode  (cfg_cmp_mode),
    .plane_sel (cfg_plane_sel),
    .cmp_color (cfg_cmp_color),
    .cmp_care  (cfg_cmp_care),
    .byte_val  (byte_w),
    .latch_load(latch_load_w),
    .latch_next(latch_next_w)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_data  = data_q;
  assign mem_rd_en = (state_q == ST_ISSUE) && !oob_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      latch_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            base_q  <= req_addr;
            cnt_q   <= req_size;
            idx_q   <= '0;
            data_q  <= '0;
            state_q <= size_ok_w ? ST_ISSUE : ST_RESP;
          end
        end
        ST_ISSUE: begin
          if (oob_w) begin
            data_q[{idx_q, 3'b000} +: 8] <= 8'hFF;
            if (last_byte_w) state_q <= ST_RESP;
            else             idx_q   <= idx_q + IDX_W'(1);
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          data_q[{idx_q, 3'b000} +: 8] <= byte_w;
          if (latch_load_w) latch_q <= latch_next_w;
          if (last_byte_w) begin
            state_q <= ST_RESP;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_ISSUE;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vga_rd_path_chk.sv
module vga_rd_path_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        mem_rd_en,
  input logic [31:0] latch_q,
  input logic        oob_w,
  input logic        latch_load_w
);
  // R2
  oob_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !oob_w);

  // R11
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R9
  latch_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q != $past(latch_q)) |-> $past(latch_load_w));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R11
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en);
endmodule

bind vga_rd_path vga_rd_path_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .mem_rd_en   (mem_rd_en),
  .latch_q     (latch_q),
  .oob_w       (oob_w),
  .latch_load_w(latch_load_w)
);

// File: tb/vga_rd_path_tb_top.sv
module vga_rd_path_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic [2:0]  req_size = 3'd1;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        mem_rd_en;
  logic [15:0] mem_word_addr;
  logic [31:0] mem_rdata = '0;
  logic        cfg_chain4 = 1'b0;
  logic        cfg_odd_even = 1'b0;
  logic        cfg_cmp_mode = 1'b0;
  logic [1:0]  cfg_plane_sel = '0;
  logic [3:0]  cfg_cmp_color = '0;
  logic [3:0]  cfg_cmp_care = '0;
  logic [31:0] latch_q;

  int vectors = 0;
  int miscompares = 0;
  int strobes = 0;
  logic [31:0] model_latch = '0;

  always #2 clk = ~clk;

  vga_rd_path dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .mem_rd_en(mem_rd_en),
    .mem_word_addr(mem_word_addr), .mem_rdata(mem_rdata),
    .cfg_chain4(cfg_chain4), .cfg_odd_even(cfg_odd_even),
    .cfg_cmp_mode(cfg_cmp_mode), .cfg_plane_sel(cfg_plane_sel),
    .cfg_cmp_color(cfg_cmp_color), .cfg_cmp_care(cfg_cmp_care),
    .latch_q(latch_q)
  );

  // Computed plane memory contents; one word per address.
  function automatic logic [31:0] mem_word(input int w);
    logic [7:0] lo, hi;
    lo = w[7:0];
    hi = w[15:8];
    return {lo ^ hi ^ 8'h69, hi + 8'h21, ~lo, lo + hi};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem_word(int'(mem_word_addr));
    if (rst_n && mem_rd_en) strobes++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural expectation of one byte; hit reports a memory access.
  function automatic logic [7:0] ref_byte(input int a, inout logic [31:0] lat,
                                          output bit hit);
    logic [31:0] w;
    int p, acc;
    hit = 1'b0;
    if (a >= 'h10000) return 8'hFF;
    hit = 1'b1;
    if (cfg_chain4) begin
      w = mem_word(a / 4);
      return w[8*(a%4) +: 8];
    end
    if (cfg_odd_even) begin
      p = (cfg_plane_sel[1] ? 2 : 0) + (a % 2);
      w = mem_word(a / 2);
      return w[8*p +: 8];
    end
    lat = mem_word(a);
    if (!cfg_cmp_mode) return lat[8*cfg_plane_sel +: 8];
    acc = 0;
    for (int n = 0; n < 4; n++) begin
      if (cfg_cmp_care[n]) acc = acc | (lat[8*n +: 8] ^ (cfg_cmp_color[n] ? 8'hFF : 8'h00));
    end
    return ~acc[7:0];
  endfunction

  task automatic run(input int addr, input int size, input string req);
    logic [31:0] exp_data = '0;
    int exp_lat = 0, exp_acc = 0, lat = 0, base_strobes;
    bit hit;
    logic [7:0] b;
    logic [31:0] held;
    if (size == 1 || size == 2 || size == 4) begin
      for (int i = 0; i < size; i++) begin
        b = ref_byte((addr + i) & 'h1FFFF, model_latch, hit);
        exp_data[8*i +: 8] = b;
        exp_lat += hit ? 2 : 1;
        exp_acc += hit ? 1 : 0;
      end
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R10 idle ready", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_addr  = addr[16:0];
    req_size  = size[2:0];
    base_strobes = strobes;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    check(rsp_data == exp_data, req, rsp_data, exp_data);
    check(lat == exp_lat, "R11 latency", 32'(lat), 32'(exp_lat));
    check(strobes - base_strobes == exp_acc, "R11 strobe count",
          32'(strobes - base_strobes), 32'(exp_acc));
    check(latch_q == model_latch, "R9 latch", latch_q, model_latch);
    check(req_ready == 1'b0, "R10 busy", 32'(req_ready), 32'd0);
    held = rsp_data;
    repeat (2) @(negedge clk);
    check(rsp_valid && rsp_data == held, "R10 hold", rsp_data, held);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R10 release", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    check(latch_q == 32'd0, "R1 latch", latch_q, 32'd0);
    rst_n = 1'b1;

    // R3 chain-4
    cfg_chain4 = 1'b1;
    run('h1235, 1, "R3 chain4 byte");
    run('h0400, 4, "R3 R8 chain4 word");
    // R2 window edge: two bytes in, two out
    run('hFFFE, 4, "R2 window edge");
    run('h1FFFF, 2, "R2 wrap");

    // R4 odd/even
    cfg_chain4 = 1'b0;
    cfg_odd_even = 1'b1;
    cfg_plane_sel = 2'd0;
    run('h2A71, 2, "R4 oddeven low");
    cfg_plane_sel = 2'd2;
    run('h2A70, 4, "R4 oddeven high");

    // R5 R6 planar mode 0
    cfg_odd_even = 1'b0;
    cfg_plane_sel = 2'd2;
    run('h0345, 1, "R5 R6 planar plane2");
    cfg_plane_sel = 2'd1;
    run('hBEEF, 2, "R6 planar plane1");

    // R7 colour compare
    cfg_cmp_mode = 1'b1;
    cfg_cmp_color = 4'b1010;
    cfg_cmp_care = 4'b1111;
    run('h5A5A, 4, "R7 compare all");
    cfg_cmp_care = 4'b0000;
    run('h0777, 1, "R7 compare none");
    cfg_cmp_color = 4'b0011;
    cfg_cmp_care = 4'b0110;
    run('h4321, 2, "R7 compare partial");

    // R8 unsupported size; R9 latch untouched by it and by chain-4
    run('h0100, 3, "R8 bad size");
    cfg_chain4 = 1'b1;
    run('h0200, 2, "R9 chain4 keeps latch");
    cfg_chain4 = 1'b0;
    run('h10010, 1, "R2 R9 oob keeps latch");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule